// File: doc/BRIEF.md
# Column window load sequencer

This block creates the pulse that pushes a new start-column pointer into an image sensor's column shift register. While the pulse is high it takes precedence over the internally generated column sync. The register's new pointer is captured on one of the two rising clock edges that the pulse spans. A pulse must meet two rules. It has to rise on a falling clock edge and stay high across exactly two rising edges. It also may not rise until the pointer register has had time to settle after its last write.

The surrounding logic raises `load_req_i` to ask for a new pointer load. It pulses `ptr_wr_i` each time the pointer register is written, and it sets `ser_if_i` when that write went over the slow serial register interface. The block counts out the settling interval for the interface used by the latest write. A request that arrives early is held until the interval expires. `busy_o` covers the whole span from the accepted request until the pulse has ended.

Top module: `colwin_load_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `col_load_o` and `busy_o` are both 0.
- R2: `col_load_o` changes only on falling clock edges. Sampled between a rising edge and the next falling edge, it holds the value it had just before that rising edge.
- R3: Every load pulse is high across exactly two consecutive rising edges and low at the third.
- R4: If the settling interval has expired, a request sampled at rising edge E makes `col_load_o` rise at the falling edge that follows E.
- R5: After a write with `ser_if_i`=0, the pulse launches no earlier than rising edge W+PAR_SETTLE_CYC+1, where W is the edge that sampled the write. PAR_SETTLE_CYC defaults to 40.
- R6: After a write with `ser_if_i`=1, the wait is CLK_HZ/1e6*SER_SETTLE_US cycles. That is 2000 cycles at the defaults of 125 MHz and 16 us.
- R7: A request that arrives during the settling interval is held. Its pulse launches at the first edge at which the interval has expired.
- R8: Every write restarts the interval. The restarted interval uses the interface mode sampled with that write, even if a request is already pending.
- R9: `busy_o` rises after the edge that samples an accepted request. It stays high until one rising edge after the pulse has fallen.
- R10: A request sampled while `busy_o` is high is ignored. No second pulse follows.
- R11: A write and a request sampled at the same edge are treated as write first, so the request waits for the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_req_i | input | 1 | Request to load a new column pointer |
| ptr_wr_i | input | 1 | Strobe for a write to the pointer register, one cycle per write |
| ser_if_i | input | 1 | Interface used by the write being strobed: 1 for serial, 0 for parallel |
| col_load_o | output | 1 | Column load pulse that launches on a falling edge and spans two rising edges |
| busy_o | output | 1 | High from an accepted request until its pulse has completed |

## Verification
A wrong settling count shows up at the ports as a pulse that starts early or late relative to the last write. The error is visible at the first falling edge where the pulse should or should not appear, so a one-cycle slip is caught at once. A wrong sequencer state shows up in one of three ways: a pulse one or three edges long, a pulse launched on a rising edge, or `busy_o` dropping or staying high one cycle off. Each of these is visible within four cycles of the request. The bench therefore compares both outputs every cycle against a cycle model. It checks them twice per cycle, once before and once after the falling edge.

// File: rtl/colwin_pkg.sv
package colwin_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_WAIT   = 3'd1,
    SQ_FIRE_A = 3'd2,
    SQ_FIRE_B = 3'd3,
    SQ_TAIL   = 3'd4
  } seq_state_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/colwin_rst_sync.sv
module colwin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/colwin_settle_timer.sv
module colwin_settle_timer #(
  parameter int unsigned PAR_CYC = 40,
  parameter int unsigned SER_CYC = 2000,
  localparam int unsigned MAX_CYC = colwin_pkg::max_u(PAR_CYC, SER_CYC),
  localparam int unsigned CW = $clog2(MAX_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic ser_i,
  output logic settled_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = wr_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (wr_i)              cnt_d = ser_i ? CW'(SER_CYC) : CW'(PAR_CYC);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign settled_o = (cnt_q == '0) && !wr_i;

  // R8
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q != '0));

  // R5
  countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !wr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/colwin_pulse_shaper.sv
module colwin_pulse_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic load_o
);
  logic load_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= fire_i;
  end

  assign load_o = load_q;
endmodule

// File: rtl/colwin_load_seq.sv
module colwin_load_seq #(
  parameter int unsigned CLK_HZ         = 125_000_000,
  parameter int unsigned PAR_SETTLE_CYC = 40,
  parameter int unsigned SER_SETTLE_US  = 16,
  localparam int unsigned SER_SETTLE_CYC = (CLK_HZ / 1_000_000) * SER_SETTLE_US
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_req_i,
  input  logic ptr_wr_i,
  input  logic ser_if_i,
  output logic col_load_o,
  output logic busy_o
);
  import colwin_pkg::*;

  logic       rst_n_int;
  logic       settled;
  logic       fire;
  seq_state_t state_q;
  seq_state_t state_d;

  colwin_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  colwin_settle_timer #(
    .PAR_CYC (PAR_SETTLE_CYC),
    .SER_CYC (SER_SETTLE_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_i      (ptr_wr_i),
    .ser_i     (ser_if_i),
    .settled_o (settled)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:   if (load_req_i) state_d = settled ? SQ_FIRE_A : SQ_WAIT;
      SQ_WAIT:   if (settled)    state_d = SQ_FIRE_A;
      SQ_FIRE_A: state_d = SQ_FIRE_B;
      SQ_FIRE_B: state_d = SQ_TAIL;
      SQ_TAIL:   state_d = SQ_IDLE;
      default:   state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) state_q <= SQ_IDLE;
    else            state_q <= state_d;
  end

  assign fire   = (state_q == SQ_FIRE_A) || (state_q == SQ_FIRE_B);
  assign busy_o = (state_q != SQ_IDLE);

  colwin_pulse_shaper u_shape (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .fire_i (fire),
    .load_o (col_load_o)
  );

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(col_load_o) |=> col_load_o ##1 !col_load_o);

  // R11
  write_blocks_launch_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ptr_wr_i |=> !$rose(col_load_o));

  // R9
  load_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    col_load_o |-> busy_o);

  // R9
  busy_ends_clean_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(busy_o) |-> !col_load_o);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(busy_o) |-> $past(load_req_i));
endmodule

// File: tb/sim_colwin_load_seq.sv
`timescale 1ns/1ps
module sim_colwin_load_seq;
  localparam int PAR_N = 40;
  localparam int SER_N = 2000;

  logic clk = 1'b0;
  logic rst_n;
  logic req, wr, ser;
  logic col_load, busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  int  e = 0;
  bit  have_w = 0;
  int  last_w = 0;
  int  last_n = 0;
  int  mph = 0;
  bit  exp_load = 0;
  bit  prev_exp = 0;
  string ctx = "R4";

  always #4 clk = ~clk;

  colwin_load_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req_i (req),
    .ptr_wr_i   (wr),
    .ser_if_i   (ser),
    .col_load_o (col_load),
    .busy_o     (busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at edge %0d: actual=%0d expected=%0d", tag, e, act, exp);
    end
  endtask

  function automatic bit settled_at(input int edge_n);
    return !have_w || (edge_n - last_w >= last_n + 1);
  endfunction

  task automatic step(input logic rq, input logic w, input logic sm);
    req = rq; wr = w; ser = sm;
    @(posedge clk);
    if (w) begin have_w = 1; last_w = e; last_n = sm ? SER_N : PAR_N; end
    case (mph)
      0: if (rq) mph = settled_at(e) ? 2 : 1;
      1: if (settled_at(e)) mph = 2;
      2: mph = 3;
      3: mph = 4;
      default: mph = 0;
    endcase
    exp_load = (mph == 2) || (mph == 3);
    #2;
    chk(col_load === prev_exp, "R2", col_load, prev_exp);
    #4;
    chk(col_load === exp_load, {"R3/", ctx}, col_load, exp_load);
    chk(busy === (mph != 0), "R9", busy, (mph != 0));
    prev_exp = exp_load;
    e++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, ser);
  endtask

  task automatic drain();
    while (mph != 0) step(1'b0, 1'b0, ser);
    idle(3);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 0; wr = 0; ser = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #3;
    chk(col_load === 1'b0 && busy === 1'b0, "R1", {col_load, busy}, 0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk);
    #2;
    chk(col_load === 1'b0 && busy === 1'b0, "R1", {col_load, busy}, 0);

    // R4: no write yet, immediate launch
    ctx = "R4";
    step(1'b1, 1'b0, 1'b0); drain();

    // R11: write and request together
    ctx = "R11";
    step(1'b1, 1'b1, 1'b0); drain();

    // R5: boundary, request exactly N and N+1 edges after write
    ctx = "R5";
    step(1'b0, 1'b1, 1'b0); idle(PAR_N - 1); step(1'b1, 1'b0, 1'b0); drain();
    step(1'b0, 1'b1, 1'b0); idle(PAR_N);     step(1'b1, 1'b0, 1'b0); drain();

    // R6: serial write, early request waits
    ctx = "R6";
    step(1'b0, 1'b1, 1'b1); idle(10); step(1'b1, 1'b0, 1'b0); drain();

    // R8: rewrite in parallel mode during pending serial wait
    ctx = "R8";
    step(1'b0, 1'b1, 1'b1); step(1'b1, 1'b0, 1'b0); idle(20);
    step(1'b0, 1'b1, 1'b0); drain();

    // R10: requests while busy are ignored
    ctx = "R10";
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0); idle(6);

    // R7: random mix
    ctx = "R7";
    for (int t = 0; t < 20; t++) begin
      logic m;
      int n, d;
      m = 1'($urandom % 2);
      n = m ? SER_N : PAR_N;
      d = int'($urandom % (n + 12));
      step(1'b0, 1'b1, m);
      idle(d);
      step(1'b1, 1'b0, m);
      if ((t % 4) == 1) begin
        idle(3);
        step(1'b0, 1'b1, 1'b0);
      end
      if ((t % 3) == 0) step(1'b1, 1'b0, m);
      drain();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule